// File: doc/BRIEF.md
# MDIO Management Master with Register Access

This block lets software talk to external Ethernet PHYs over the two-wire management bus. A 32-bit word-addressed register port exposes four registers: settings and status, target selection, data, and an extended register pointer. Software sets the clock ratio, framing style and launch edge in the settings register. It then starts a frame with a single write. It polls the busy flag until the frame has left the wire. After a read it collects the 16-bit result from the data register.

The block builds complete management frames: a preamble of ones, the start code, the operation code, two 5-bit address fields, a turnaround and 16 data bits. It supports both the short framing (start code 01) and the extended framing (start code 00). In extended framing a separate address frame sets the register pointer inside the selected device. The management clock comes from a programmable divider and is held low between frames. The data pin is driven through separate out, output-enable and in signals, so a pad cell or an on-chip tri-state can sit outside. During a read the master releases the pin at the turnaround. A PHY that fails to pull the second turnaround bit low is reported as a read error.

Top module: `mdio_master`

## Requirements
- R1: After reset, all four registers read as zero, MDC is low and the data pin is released (`mdio_oe` = 0). The register word offsets are: settings 0x0, target 0x4, data 0x8, pointer 0xC.
- R2: Settings bit 0 reads 1 from the clock edge that accepts a frame-starting write until the frame ends. Any register write made while it is 1 is ignored.
- R3: Every frame is sent MSB first as 64 bits: 32 ones, start code, 2-bit opcode, port (target bits 9:5), device/register (target bits 4:0), 2-bit turnaround, then 16 data bits. In short framing (settings bit 6 = 0) the start code is 01. A write to the data register sends opcode 01 with turnaround 10 and the written bits 15:0.
- R4: In extended framing (settings bit 6 = 1) the start code is 00. A pointer-register write sends an address frame (opcode 00) that carries the written bits 15:0. Data writes use opcode 01 and reads use opcode 11. In short framing a pointer write only stores the value and starts no frame.
- R5: MDC stays high for N system clocks and low for N system clocks, where N is settings bits 15:8 (0 counts as 1). N = 129 is supported. MDC is low whenever no frame is in progress.
- R6: With settings bit 23 = 1, the data pin changes only on MDC falling edges and is valid at each rising edge. With bit 23 = 0, it changes only on MDC rising edges and is valid at each falling edge. The master samples `mdio_i` on the edge where its own output is valid.
- R7: Writing the target register with bit 15 = 1 starts a read: short framing uses opcode 10 and extended framing uses opcode 11. `mdio_oe` is 0 from the first turnaround bit to the end of the frame. The 16 bits sampled MSB first then read back from data register bits 15:0.
- R8: Settings bit 1 is set when `mdio_i` is high at the second turnaround bit of a read. It is cleared when the next frame starts.
- R9: The target register reads back bits 9:0 as written. Bit 15 is a start request that always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe for one cycle |
| reg_addr | input | 4 | Byte address; bits 3:2 select the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data pin output value |
| mdio_oe | output | 1 | Data pin output enable |
| mdio_i | input | 1 | Data pin input value |

## Verification
The embedded assertions check these rules on every cycle:
- MDC is never held longer than the programmed half period and is low while idle.
- The data pin changes only on the selected launch edge.
- The pin stays released once a read has let go of it.
- An accepted start always raises busy.
- Writes arriving during a frame leave the stored settings and data untouched.
- The error flag is clear whenever a frame begins.

Only the directed scenarios can show the frame contents bit by bit for each framing style and opcode. The same applies to the data a read returns and the error raised by a silent PHY. The exact MDC period at the largest tested divisor, and the fact that a pointer write in short framing launches nothing, are also left to the scenarios.

// File: rtl/mdio_pkg.sv
// Package: shared constants and types for the management master.
// Assumes a fixed 64-bit frame and 16-bit data words.
package mdio_pkg;
    localparam int FRAME_LEN  = 64;
    localparam int PRE_LEN    = 32;
    localparam int TA_IDX     = 46;
    localparam int TA_ACK_IDX = 47;
    localparam int RD_IDX     = 48;
    localparam int FLD_W      = 5;
    localparam int WORD_W     = 16;
    localparam int DIV_W      = 8;
    localparam int IDX_W      = $clog2(FRAME_LEN);

    localparam logic [1:0] W_CFG  = 2'd0;
    localparam logic [1:0] W_CTL  = 2'd1;
    localparam logic [1:0] W_DATA = 2'd2;
    localparam logic [1:0] W_PTR  = 2'd3;

    typedef enum logic [1:0] {
        FK_WRITE = 2'd0,
        FK_READ  = 2'd1,
        FK_ADDR  = 2'd2
    } frame_kind_e;

    typedef struct packed {
        frame_kind_e        kind;
        logic               c45;
        logic [FLD_W-1:0]   port;
        logic [FLD_W-1:0]   dev;
        logic [WORD_W-1:0]  data;
    } frame_req_t;
endpackage

// File: rtl/mdio_clkgen.sv
// Module: management clock divider.
// While run is high, MDC toggles every max(half,1) system clocks, starting low.
// rise_tick/fall_tick mark the clock edge on which MDC goes high/low.
// Assumes half is stable while run is high.
module mdio_clkgen
    import mdio_pkg::*;
#(
    parameter int HW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [HW-1:0] half,
    output logic          mdc,
    output logic          rise_tick,
    output logic          fall_tick
);
    logic [HW-1:0] cnt;
    logic [HW-1:0] lim;
    logic          wrap;

    // Effective half period, zero treated as one.
    always_comb lim = (half == '0) ? HW'(1) : half;

    // Toggle point of the divider.
    always_comb wrap = run && (cnt == lim - HW'(1));
    always_comb rise_tick = wrap && !mdc;
    always_comb fall_tick = wrap && mdc;

    // Divider counter and MDC flop; idle holds MDC low.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + HW'(1);
        end
    end

    // Checker state: cycles MDC has held its current level.
    logic          mdc_q;
    logic [HW:0]   hold;
    always_ff @(posedge clk) begin
        mdc_q <= mdc;
        if (!rst_n || !run)  hold <= '0;
        else if (mdc != mdc_q) hold <= (HW+1)'(1);
        else                 hold <= hold + (HW+1)'(1);
    end

    assert_mdc_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (hold <= {1'b0, lim}));
endmodule

// File: rtl/mdio_regs.sv
// Module: register file and frame request decode.
// Words: settings/status, target, data, pointer (byte address bits 3:2).
// Writes are accepted only while no frame is in progress; an accepted write
// to data, target-with-read, or pointer (extended mode) raises start.
module mdio_regs
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        addr,
    input  logic [31:0]       wdata,
    input  logic              busy,
    input  logic              rd_err,
    input  logic              fin,
    input  logic              fin_rd,
    input  logic [WORD_W-1:0] fin_word,
    output logic [31:0]       rdata,
    output logic [DIV_W-1:0]  half,
    output logic              neg,
    output logic              start,
    output frame_req_t        req
);
    logic [1:0]        word;
    logic              acc;
    logic              c45_q;
    logic [FLD_W-1:0]  port_q;
    logic [FLD_W-1:0]  dev_q;
    logic [WORD_W-1:0] data_q;
    logic [WORD_W-1:0] ptr_q;

    always_comb word = addr[3:2];
    always_comb acc  = wr_en && !busy;

    // Decode a frame request from the accepted write.
    always_comb begin
        start    = 1'b0;
        req.kind = FK_WRITE;
        req.c45  = c45_q;
        req.port = port_q;
        req.dev  = dev_q;
        req.data = data_q;
        if (acc) begin
            case (word)
                W_CTL: if (wdata[15]) begin
                    start    = 1'b1;
                    req.kind = FK_READ;
                    req.port = wdata[9:5];
                    req.dev  = wdata[4:0];
                end
                W_DATA: begin
                    start    = 1'b1;
                    req.data = wdata[WORD_W-1:0];
                end
                W_PTR: if (c45_q) begin
                    start    = 1'b1;
                    req.kind = FK_ADDR;
                    req.data = wdata[WORD_W-1:0];
                end
                default: ;
            endcase
        end
    end

    // Register storage; read results land in the data register at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half   <= '0;
            c45_q  <= 1'b0;
            neg    <= 1'b0;
            port_q <= '0;
            dev_q  <= '0;
            data_q <= '0;
            ptr_q  <= '0;
        end else if (acc) begin
            case (word)
                W_CFG: begin
                    half  <= wdata[8 +: DIV_W];
                    c45_q <= wdata[6];
                    neg   <= wdata[23];
                end
                W_CTL: begin
                    port_q <= wdata[9:5];
                    dev_q  <= wdata[4:0];
                end
                W_DATA:  data_q <= wdata[WORD_W-1:0];
                default: ptr_q  <= wdata[WORD_W-1:0];
            endcase
        end else if (fin && fin_rd) begin
            data_q <= fin_word;
        end
    end

    // Read-back multiplexer.
    always_comb begin
        case (word)
            W_CFG:   rdata = {8'h00, neg, 7'h00, half, 1'b0, c45_q, 4'h0, rd_err, busy};
            W_CTL:   rdata = {22'h0, port_q, dev_q};
            W_DATA:  rdata = {16'h0, data_q};
            default: rdata = {16'h0, ptr_q};
        endcase
    end

    assert_busy_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && word == W_DATA && !fin) |=> (data_q == $past(data_q)));
    assert_busy_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && word == W_CFG) |=> (half == $past(half) && neg == $past(neg)));
endmodule

// File: rtl/mdio_frame.sv
// Module: frame sequencer.
// Loads a 64-bit frame on start and shifts it out MSB first, one bit per
// MDC period. The output advances on the launch edge chosen by neg.
// Reads release the pin from the turnaround on, check the acknowledge bit
// and collect 16 bits. Assumes start arrives only while idle.
module mdio_frame
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  frame_req_t        req,
    input  logic              neg,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rd_err,
    output logic              fin,
    output logic              fin_rd,
    output logic [WORD_W-1:0] fin_word
);
    logic [FRAME_LEN-1:0] shreg;
    logic [FRAME_LEN-1:0] frame;
    logic [IDX_W-1:0]     pcnt;
    logic [IDX_W-1:0]     disp;
    logic [IDX_W-1:0]     disp_nx;
    logic [WORD_W-1:0]    rx;
    logic                 is_read;
    logic                 last;
    logic                 launch;
    logic                 sample;

    // Assemble the frame image from the request.
    always_comb begin
        logic [1:0] st, op, ta;
        logic [WORD_W-1:0] dat;
        st  = req.c45 ? 2'b00 : 2'b01;
        case (req.kind)
            FK_READ: op = req.c45 ? 2'b11 : 2'b10;
            FK_ADDR: op = 2'b00;
            default: op = 2'b01;
        endcase
        ta  = (req.kind == FK_READ) ? 2'b11 : 2'b10;
        dat = (req.kind == FK_READ) ? '1 : req.data;
        frame = {{PRE_LEN{1'b1}}, st, op, req.port, req.dev, ta, dat};
    end

    // Edge qualification for output advance and input sampling.
    always_comb begin
        last     = (pcnt == IDX_W'(FRAME_LEN - 1));
        launch   = busy && (neg ? (fall_tick && !last) : (rise_tick && pcnt != '0));
        sample   = busy && (neg ? rise_tick : fall_tick);
        disp_nx  = disp + IDX_W'(1);
        fin      = busy && fall_tick && last;
        fin_rd   = is_read;
        fin_word = neg ? rx : {rx[WORD_W-2:0], mdio_i};
    end

    // Frame shifter, pin drive and period counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            shreg   <= '0;
            pcnt    <= '0;
            disp    <= '0;
            is_read <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                busy    <= 1'b1;
                shreg   <= frame;
                mdio_o  <= frame[FRAME_LEN-1];
                mdio_oe <= 1'b1;
                pcnt    <= '0;
                disp    <= '0;
                is_read <= (req.kind == FK_READ);
            end
        end else begin
            if (launch) begin
                shreg  <= shreg << 1;
                mdio_o <= shreg[FRAME_LEN-2];
                disp   <= disp_nx;
                if (is_read && disp_nx >= IDX_W'(TA_IDX)) mdio_oe <= 1'b0;
            end
            if (fall_tick) begin
                if (last) begin
                    busy    <= 1'b0;
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b0;
                end else begin
                    pcnt <= pcnt + IDX_W'(1);
                end
            end
        end
    end

    // Read capture and acknowledge check; error cleared at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx     <= '0;
            rd_err <= 1'b0;
        end else if (!busy && start) begin
            rx     <= '0;
            rd_err <= 1'b0;
        end else if (sample && is_read) begin
            if (pcnt == IDX_W'(TA_ACK_IDX) && mdio_i) rd_err <= 1'b1;
            if (pcnt >= IDX_W'(RD_IDX)) rx <= {rx[WORD_W-2:0], mdio_i};
        end
    end

    assert_err_clear_at_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !rd_err);
    assert_write_drives_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !is_read) |-> mdio_oe);
    assert_release_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mdio_oe) |=> (!mdio_oe || !busy));
endmodule

// File: rtl/mdio_master.sv
// Module: top of the management master.
// Ties the register file, clock divider and frame sequencer together.
// The divider runs only while a frame is in progress.
module mdio_master
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              busy, rd_err, fin, fin_rd, start, neg;
    logic              rise_tick, fall_tick;
    logic [DIV_W-1:0]  half;
    logic [WORD_W-1:0] fin_word;
    frame_req_t        req;

    mdio_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .busy(busy), .rd_err(rd_err), .fin(fin), .fin_rd(fin_rd), .fin_word(fin_word),
        .rdata(reg_rdata), .half(half), .neg(neg), .start(start), .req(req)
    );

    mdio_clkgen #(.HW(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(busy), .half(half),
        .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    mdio_frame u_frame (
        .clk(clk), .rst_n(rst_n), .start(start), .req(req), .neg(neg),
        .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
        .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_err(rd_err),
        .fin(fin), .fin_rd(fin_rd), .fin_word(fin_word)
    );

    assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    assert_mdc_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);
    assert_neg_launch_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && neg && !$stable(mdio_o)) |-> $fell(mdc));
    assert_pos_launch_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !neg && !$stable(mdio_o)) |-> $rose(mdc));
endmodule

// File: tb/tb_mdio_master.sv
// Directed bench: each task runs one scenario and checks its own results.
module tb_mdio_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    // PHY responder / capture state
    logic        mon_neg = 1'b1;
    logic        phy_en = 1'b0;
    logic [15:0] phy_data = 16'h0;
    int          cap_cnt = 64;
    int          bad_edge = 0;
    logic [63:0] cap_out, cap_oe;
    logic        prev_mdc = 1'b0, prev_out = 1'b1, prev_oe = 1'b0;

    mdio_master dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #5 clk = ~clk;

    function automatic logic phy_bit(input int k);
        if (!phy_en) return 1'b1;
        if (k == 47) return 1'b0;
        if (k >= 48 && k <= 63) return phy_data[63 - k];
        return 1'b1;
    endfunction

    // Capture each bit on the edge where it must be valid; check launch edges.
    always @(negedge clk) begin
        if (mdc != prev_mdc && mdc == mon_neg && cap_cnt < 64) begin
            cap_out[63 - cap_cnt] = prev_out;
            cap_oe[63 - cap_cnt]  = prev_oe;
            cap_cnt = cap_cnt + 1;
            mdio_i = phy_bit(cap_cnt);
        end
        if (mdio_o != prev_out && cap_cnt > 0 && cap_cnt < 64 &&
            (mdc == prev_mdc || mdc == mon_neg))
            bad_edge = bad_edge + 1;
        prev_mdc = mdc;
        prev_out = mdio_o;
        prev_oe  = mdio_oe;
    end

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] cfgw(input logic [7:0] h, input logic c45, input logic ng);
        return {8'h00, ng, 7'h00, h, 1'b0, c45, 6'h00};
    endfunction

    task automatic arm(input logic en, input logic [15:0] d, input logic ng);
        phy_en = en; phy_data = d; mon_neg = ng;
        cap_cnt = 0; bad_edge = 0; mdio_i = 1'b1;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 40000; i++) begin
            rd(4'h0, v);
            if (!v[0]) break;
        end
    endtask

    task automatic check_frame(input logic [1:0] st, input logic [1:0] op, input logic [4:0] port,
                               input logic [4:0] dev, input bit rdf, input logic [15:0] dat,
                               input string rq);
        logic [63:0] eoe;
        chk(cap_cnt == 64, rq, 64'(cap_cnt), 64);
        chk(cap_out[63:32] == 32'hFFFF_FFFF, {rq, " preamble"}, 64'(cap_out[63:32]), 64'hFFFF_FFFF);
        chk(cap_out[31:18] == {st, op, port, dev}, {rq, " header"},
            64'(cap_out[31:18]), 64'({st, op, port, dev}));
        eoe = rdf ? {{46{1'b1}}, 18'h0} : '1;
        chk(cap_oe == eoe, {rq, " R7 output enable"}, cap_oe, eoe);
        if (!rdf)
            chk(cap_out[17:0] == {2'b10, dat}, {rq, " turnaround+data"},
                64'(cap_out[17:0]), 64'({2'b10, dat}));
        chk(bad_edge == 0, "R6 launch edge", 64'(bad_edge), 0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(4'(a * 4), v);
            chk(v == 32'h0, "R1 reset register", 64'(v), 0);
        end
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 reset pins", 64'({mdc, mdio_oe}), 0);
    endtask

    task automatic t_c22_write();
        logic [31:0] v;
        int n;
        logic p;
        wr(4'h0, cfgw(8'd2, 1'b0, 1'b1));
        wr(4'h4, {22'h0, 5'h13, 5'h0A});
        arm(1'b0, 16'h0, 1'b1);
        wr(4'h8, 32'h0000_BEEF);
        rd(4'h0, v);
        chk(v[0] == 1'b1, "R2 busy after start", 64'(v[0]), 1);
        p = mdc;
        for (int i = 0; i < 100; i++) begin @(negedge clk); if (mdc && !p) break; p = mdc; end
        n = 0; p = mdc;
        for (int i = 0; i < 100; i++) begin @(negedge clk); n++; if (mdc && !p) break; p = mdc; end
        chk(n == 4, "R5 MDC period half=2", 64'(n), 4);
        wait_idle();
        check_frame(2'b01, 2'b01, 5'h13, 5'h0A, 1'b0, 16'hBEEF, "R3 short write");
    endtask

    task automatic t_c22_read();
        logic [31:0] v;
        wr(4'h0, cfgw(8'd3, 1'b0, 1'b0));
        arm(1'b1, 16'h5A3C, 1'b0);
        wr(4'h4, {16'h0, 1'b1, 5'h0, 5'h01, 5'h02});
        wait_idle();
        check_frame(2'b01, 2'b10, 5'h01, 5'h02, 1'b1, 16'h0, "R7 short read");
        rd(4'h8, v);
        chk(v == 32'h5A3C, "R7 read data", 64'(v), 64'h5A3C);
        rd(4'h0, v);
        chk(v[1] == 1'b0, "R8 no error on ack", 64'(v[1]), 0);
        rd(4'h4, v);
        chk(v == 32'h0000_0022, "R9 target readback", 64'(v), 64'h22);
    endtask

    task automatic t_c45();
        logic [31:0] v;
        wr(4'h0, cfgw(8'd1, 1'b1, 1'b1));
        wr(4'h4, {22'h0, 5'h03, 5'h07});
        arm(1'b0, 16'h0, 1'b1);
        wr(4'hC, 32'hABCD_1234);
        wait_idle();
        check_frame(2'b00, 2'b00, 5'h03, 5'h07, 1'b0, 16'h1234, "R4 address frame");
        arm(1'b0, 16'h0, 1'b1);
        wr(4'h8, 32'h0000_0F0F);
        wait_idle();
        check_frame(2'b00, 2'b01, 5'h03, 5'h07, 1'b0, 16'h0F0F, "R4 extended write");
        arm(1'b1, 16'hC0DE, 1'b1);
        wr(4'h4, {16'h0, 1'b1, 5'h0, 5'h03, 5'h07});
        wait_idle();
        check_frame(2'b00, 2'b11, 5'h03, 5'h07, 1'b1, 16'h0, "R4 extended read");
        rd(4'h8, v);
        chk(v == 32'hC0DE, "R7 extended read data", 64'(v), 64'hC0DE);
    endtask

    task automatic t_read_error();
        logic [31:0] v;
        wr(4'h0, cfgw(8'd2, 1'b0, 1'b1));
        arm(1'b0, 16'h0, 1'b1);
        wr(4'h4, {16'h0, 1'b1, 5'h0, 5'h04, 5'h01});
        wait_idle();
        rd(4'h0, v);
        chk(v[1] == 1'b1, "R8 error on silent PHY", 64'(v[1]), 1);
        arm(1'b0, 16'h0, 1'b1);
        wr(4'h8, 32'h0000_1357);
        rd(4'h0, v);
        chk(v[1:0] == 2'b01, "R8 error cleared at next start", 64'(v[1:0]), 1);
        wait_idle();
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        wr(4'h0, cfgw(8'd2, 1'b0, 1'b1));
        wr(4'h4, {22'h0, 5'h05, 5'h06});
        arm(1'b0, 16'h0, 1'b1);
        wr(4'h8, 32'h0000_2468);
        wr(4'h8, 32'h0000_1111);
        wr(4'h0, cfgw(8'd9, 1'b1, 1'b0));
        wr(4'h4, 32'h0000_03FF);
        wait_idle();
        check_frame(2'b01, 2'b01, 5'h05, 5'h06, 1'b0, 16'h2468, "R2 frame unaffected");
        rd(4'h8, v);
        chk(v == 32'h2468, "R2 data write ignored while busy", 64'(v), 64'h2468);
        rd(4'h0, v);
        chk(v == cfgw(8'd2, 1'b0, 1'b1), "R2 settings write ignored while busy", 64'(v),
            64'(cfgw(8'd2, 1'b0, 1'b1)));
        rd(4'h4, v);
        chk(v == 32'h00A6, "R2 target write ignored while busy", 64'(v), 64'hA6);
    endtask

    task automatic t_c22_ptr();
        logic [31:0] v;
        wr(4'h0, cfgw(8'd2, 1'b0, 1'b1));
        wr(4'hC, 32'h0000_55AA);
        rd(4'h0, v);
        chk(v[0] == 1'b0, "R4 pointer write starts nothing in short mode", 64'(v[0]), 0);
        repeat (10) @(negedge clk);
        chk(mdc == 1'b0, "R4 MDC idle after pointer write", 64'(mdc), 0);
        rd(4'hC, v);
        chk(v == 32'h55AA, "R4 pointer stored", 64'(v), 64'h55AA);
    endtask

    task automatic t_big_div();
        int n;
        logic p;
        wr(4'h0, cfgw(8'd129, 1'b0, 1'b1));
        arm(1'b0, 16'h0, 1'b1);
        wr(4'h8, 32'h0000_00FF);
        p = mdc;
        for (int i = 0; i < 600; i++) begin @(negedge clk); if (mdc && !p) break; p = mdc; end
        n = 0; p = mdc;
        for (int i = 0; i < 600; i++) begin @(negedge clk); n++; if (mdc && !p) break; p = mdc; end
        chk(n == 258, "R5 MDC period half=129", 64'(n), 258);
        wait_idle();
        check_frame(2'b01, 2'b01, 5'h05, 5'h06, 1'b0, 16'h00FF, "R5 frame at divisor 258");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_c22_write();
        t_c22_read();
        t_c45();
        t_read_error();
        t_busy_ignore();
        t_c22_ptr();
        t_big_div();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule